// File: doc/BRIEF.md
# Multichannel UART Interrupt Aggregator

This block collects the service requests of eight serial channels and one shared timer. It presents them to a host as a small set of byte-wide global status registers. Each channel keeps four registered source flags: line error, receive data, transmit empty and modem change. A per-channel priority encoder turns those flags into a 3-bit source code. The host reads a summary byte with one bit per channel, then fetches the packed 24-bit code field to see what each channel wants without visiting the channels one by one.

Pending sources are cleared by the host's reads of the matching per-channel status register. The bus decoding of those registers lives elsewhere and arrives here as one-cycle read strobes per channel. The shared timer's time-out is shown only in channel 0's code, as the lowest-priority source. It is cleared by a read of a dedicated timer status address. A single interrupt line is the OR of all pending channels.

Top module: `uart_irq_agg`

## Requirements
- R1: Read address 0 returns the summary byte; bit N is 1 exactly when channel N has any pending source.
- R2: The 24 code bits are packed with channel N at bits 3N+2:3N; address 1 returns bits 7:0, address 2 bits 15:8, address 3 bits 23:16.
- R3: A channel's code is its highest-priority pending source: 1 line error, then 2 receive data, then 3 transmit empty, then 4 modem change, then 7 timer (channel 0 only); 0 when nothing is pending.
- R4: Code 7 appears only in channel 0's field, and only while the timer flag is set; channels 1 to 7 never show 7.
- R5: Source set pulses arrive on src_set_i bit 4N+k for channel N, with k = 0 line error, 1 receive data, 2 transmit empty, 3 modem change. A line-status read strobe clears the source only when code 1 is active. An interrupt-status read strobe clears it when code 2 or 3 is active. A modem-status read strobe clears it when code 4 is active. A strobe that does not match the active code changes nothing.
- R6: Address 4 returns the timer flag in bit 0. A read of address 4 with rd_en_i high clears it, after which channel 0's code shows its remaining UART source or 0.
- R7: A channel's code is 0 exactly when its summary bit is 0.
- R8: irq_o is high while any summary bit is set, and falls right after the clock edge that clears the last pending source.
- R9: Reset clears every source flag and the timer flag, so all registers read 0 and irq_o is low.
- R10: When a set pulse and a clearing read hit the same source, or a timer event coincides with a timer-address read, the source stays pending.
- R11: Addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_set_i | input | 32 | Per-channel source set pulses, 4 per channel |
| isr_rd_i | input | 8 | Per-channel interrupt-status read strobes |
| lsr_rd_i | input | 8 | Per-channel line-status read strobes |
| msr_rd_i | input | 8 | Per-channel modem-status read strobes |
| tmr_evt_i | input | 1 | Timer time-out pulse |
| rd_en_i | input | 1 | Host read strobe for the global registers |
| rd_addr_i | input | 3 | Global register address |
| rd_data_o | output | 8 | Global register read data, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions take for granted that strobes and set pulses are one cycle long and sampled on the rising edge. They also assume that rd_addr_i is valid whenever rd_en_i is high, so that a read of the timer address clears the timer flag in the cycle it is presented. The stimulus drives every pulse for exactly one clock, starting and ending on the falling edge. It raises rd_en_i only when it means to clear the timer, and peeks at the other addresses with rd_en_i low. The stimulus places coinciding set and clear events on purpose, to exercise the set-wins rule.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int SRC_N  = 4;
  localparam int CODE_W = 3;
  localparam int DATA_W = 8;

  localparam int SRC_LINE = 0;
  localparam int SRC_RX   = 1;
  localparam int SRC_TX   = 2;
  localparam int SRC_MDM  = 3;

  localparam logic [CODE_W-1:0] CODE_NONE = 3'd0;
  localparam logic [CODE_W-1:0] CODE_LINE = 3'd1;
  localparam logic [CODE_W-1:0] CODE_RX   = 3'd2;
  localparam logic [CODE_W-1:0] CODE_TX   = 3'd3;
  localparam logic [CODE_W-1:0] CODE_MDM  = 3'd4;
  localparam logic [CODE_W-1:0] CODE_TMR  = 3'd7;
endpackage

// File: rtl/uart_irq_chan.sv
module uart_irq_chan
  import uart_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SRC_N-1:0]  set_i,
  input  logic              isr_rd_i,
  input  logic              lsr_rd_i,
  input  logic              msr_rd_i,
  input  logic              tmr_pend_i,
  output logic [CODE_W-1:0] code_o,
  output logic              pend_o
);

  logic [SRC_N-1:0] flg_q;
  logic [SRC_N-1:0] clr;

  always_comb begin
    if      (flg_q[SRC_LINE]) code_o = CODE_LINE;
    else if (flg_q[SRC_RX])   code_o = CODE_RX;
    else if (flg_q[SRC_TX])   code_o = CODE_TX;
    else if (flg_q[SRC_MDM])  code_o = CODE_MDM;
    else if (tmr_pend_i)      code_o = CODE_TMR;
    else                      code_o = CODE_NONE;
  end

  assign pend_o = (code_o != CODE_NONE);

  // a read only retires the source it reports
  always_comb begin
    clr = '0;
    case (code_o)
      CODE_LINE: clr[SRC_LINE] = lsr_rd_i;
      CODE_RX:   clr[SRC_RX]   = isr_rd_i;
      CODE_TX:   clr[SRC_TX]   = isr_rd_i;
      CODE_MDM:  clr[SRC_MDM]  = msr_rd_i;
      default:   clr = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flg_q <= '0;
    else         flg_q <= (flg_q & ~clr) | set_i;
  end

endmodule

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
  import uart_irq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int NREG   = 3,
  parameter int ADDR_W = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     rd_en_i,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  input  logic                     tmr_evt_i,
  input  logic [NUM_CH-1:0]        sum_i,
  input  logic [NUM_CH*CODE_W-1:0] codes_i,
  output logic [DATA_W-1:0]        rd_data_o,
  output logic                     tmr_pend_o
);

  localparam int CODE_BITS = NUM_CH * CODE_W;
  localparam int TMR_ADDR  = NREG + 1;

  logic                     tmr_q;
  logic                     tmr_hit;
  logic [NREG*DATA_W-1:0]   codes_pad;

  assign tmr_hit    = rd_en_i && (rd_addr_i == ADDR_W'(TMR_ADDR));
  assign tmr_pend_o = tmr_q;

  // event wins over a coincident clearing read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tmr_q <= 1'b0;
    else if (tmr_evt_i) tmr_q <= 1'b1;
    else if (tmr_hit)   tmr_q <= 1'b0;
  end

  always_comb begin
    codes_pad = '0;
    codes_pad[CODE_BITS-1:0] = codes_i;
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == '0) rd_data_o[NUM_CH-1:0] = sum_i;
    for (int r = 0; r < NREG; r++) begin
      if (rd_addr_i == ADDR_W'(r + 1)) rd_data_o = codes_pad[r*DATA_W +: DATA_W];
    end
    if (rd_addr_i == ADDR_W'(TMR_ADDR)) rd_data_o[0] = tmr_q;
  end

endmodule

// File: rtl/uart_irq_agg.sv
module uart_irq_agg
  import uart_irq_pkg::*;
#(
  parameter  int NUM_CH = 8,
  localparam int NREG   = (NUM_CH * CODE_W + DATA_W - 1) / DATA_W,
  localparam int ADDR_W = $clog2(NREG + 2)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_CH*SRC_N-1:0] src_set_i,
  input  logic [NUM_CH-1:0]       isr_rd_i,
  input  logic [NUM_CH-1:0]       lsr_rd_i,
  input  logic [NUM_CH-1:0]       msr_rd_i,
  input  logic                    tmr_evt_i,
  input  logic                    rd_en_i,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  output logic [DATA_W-1:0]       rd_data_o,
  output logic                    irq_o
);

  localparam int TMR_ADDR = NREG + 1;

  logic [NUM_CH-1:0]        sum_w;
  logic [NUM_CH*CODE_W-1:0] codes_w;
  logic                     tmr_pend;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    uart_irq_chan u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .set_i      (src_set_i[c*SRC_N +: SRC_N]),
      .isr_rd_i   (isr_rd_i[c]),
      .lsr_rd_i   (lsr_rd_i[c]),
      .msr_rd_i   (msr_rd_i[c]),
      .tmr_pend_i ((c == 0) ? tmr_pend : 1'b0),
      .code_o     (codes_w[c*CODE_W +: CODE_W]),
      .pend_o     (sum_w[c])
    );
  end

  uart_irq_regs #(
    .NUM_CH (NUM_CH),
    .NREG   (NREG),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_en_i    (rd_en_i),
    .rd_addr_i  (rd_addr_i),
    .tmr_evt_i  (tmr_evt_i),
    .sum_i      (sum_w),
    .codes_i    (codes_w),
    .rd_data_o  (rd_data_o),
    .tmr_pend_o (tmr_pend)
  );

  assign irq_o = |sum_w;

endmodule

// File: rtl/uart_irq_agg_chk.sv
module uart_irq_agg_chk #(
  parameter int NUM_CH   = 8,
  parameter int ADDR_W   = 3,
  parameter int TMR_ADDR = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NUM_CH-1:0]     pend_i,
  input logic [NUM_CH*3-1:0]   codes_i,
  input logic                  irq_o,
  input logic                  tmr_evt_i,
  input logic                  rd_en_i,
  input logic [ADDR_W-1:0]     rd_addr_i,
  input logic [7:0]            rd_data_o
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_idle
    a_r7_code_zero_iff_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_i[i] == 1'b0) == (codes_i[3*i +: 3] == 3'd0));
  end

  for (genvar i = 1; i < NUM_CH; i++) begin : g_upper
    a_r4_no_code7_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
      codes_i[3*i +: 3] != 3'd7);
  end

  a_r8_irq_vs_summary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == '0) |-> (irq_o == (rd_data_o != 8'd0)));

  a_r6_tmr_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_addr_i == ADDR_W'(TMR_ADDR) && !tmr_evt_i) |=> (codes_i[2:0] != 3'd7));

  a_r6_tmr_evt_pends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_evt_i |=> pend_i[0]);

endmodule

bind uart_irq_agg uart_irq_agg_chk #(
  .NUM_CH   (NUM_CH),
  .ADDR_W   (ADDR_W),
  .TMR_ADDR (TMR_ADDR)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pend_i    (sum_w),
  .codes_i   (codes_w),
  .irq_o     (irq_o),
  .tmr_evt_i (tmr_evt_i),
  .rd_en_i   (rd_en_i),
  .rd_addr_i (rd_addr_i),
  .rd_data_o (rd_data_o)
);

// File: tb/uart_irq_agg_bench.sv
`timescale 1ns/1ps
module uart_irq_agg_bench;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] src_set_i = '0;
  logic [7:0]  isr_rd_i = '0, lsr_rd_i = '0, msr_rd_i = '0;
  logic        tmr_evt_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [2:0]  rd_addr_i = '0;
  logic [7:0]  rd_data_o;
  logic        irq_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  logic [3:0] mf [8];
  logic       mt;

  always #10 clk_i = ~clk_i;

  uart_irq_agg u_uart_irq_agg (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_set_i(src_set_i),
    .isr_rd_i(isr_rd_i), .lsr_rd_i(lsr_rd_i), .msr_rd_i(msr_rd_i),
    .tmr_evt_i(tmr_evt_i), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] mcode(input int ch);
    if (mf[ch][0]) return 3'd1;
    if (mf[ch][1]) return 3'd2;
    if (mf[ch][2]) return 3'd3;
    if (mf[ch][3]) return 3'd4;
    if (ch == 0 && mt) return 3'd7;
    return 3'd0;
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 8; c++) mf[c] = '0;
    mt = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr_i = a;
    #1;
    d = rd_data_o;
  endtask

  task automatic read_codes(output logic [23:0] v);
    logic [7:0] b;
    rd(3'd1, b); v[7:0]   = b;
    rd(3'd2, b); v[15:8]  = b;
    rd(3'd3, b); v[23:16] = b;
    rd_addr_i = 3'd0;
  endtask

  task automatic apply(input logic [31:0] s, input logic [7:0] ir, input logic [7:0] lr,
                       input logic [7:0] mr, input logic te, input logic tc);
    logic [3:0] clr;
    @(negedge clk_i);
    src_set_i = s; isr_rd_i = ir; lsr_rd_i = lr; msr_rd_i = mr; tmr_evt_i = te;
    if (tc) begin rd_en_i = 1'b1; rd_addr_i = 3'd4; end
    for (int c = 0; c < 8; c++) begin
      clr = '0;
      case (mcode(c))
        3'd1: clr[0] = lr[c];
        3'd2: clr[1] = ir[c];
        3'd3: clr[2] = ir[c];
        3'd4: clr[3] = mr[c];
        default: clr = '0;
      endcase
      mf[c] = (mf[c] & ~clr) | s[c*4 +: 4];
    end
    if (tc) mt = 1'b0;
    if (te) mt = 1'b1;
    @(negedge clk_i);
    src_set_i = '0; isr_rd_i = '0; lsr_rd_i = '0; msr_rd_i = '0; tmr_evt_i = 1'b0;
    rd_en_i = 1'b0; rd_addr_i = 3'd0;
  endtask

  task automatic check_all();
    logic [7:0]  d;
    logic [7:0]  esum;
    logic [23:0] ecodes;
    logic [23:0] acodes;
    for (int c = 0; c < 8; c++) begin
      ecodes[c*3 +: 3] = mcode(c);
      esum[c] = (mcode(c) != 3'd0);
    end
    rd(3'd0, d); chk("R1 summary", d, esum);
    chk("R8 irq", irq_o, |esum);
    read_codes(acodes);
    chk("R2 codes", acodes, ecodes);
    for (int c = 0; c < 8; c++) chk("R7 zero iff idle", acodes[c*3 +: 3] == 3'd0, d[c] == 1'b0);
    rd(3'd4, d); chk("R6 tmr status", d, {7'd0, mt});
    for (int a = 5; a < 8; a++) begin
      rd(3'(a), d); chk("R11 unused addr", d, 8'd0);
    end
    rd_addr_i = 3'd0;
  endtask

  task automatic code_of(input int ch, output logic [2:0] c);
    logic [23:0] v;
    read_codes(v);
    c = v[ch*3 +: 3];
  endtask

  task automatic t_reset();
    model_reset();
    rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check_all();  // R9 during reset
    chk("R9 irq low in reset", irq_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_layout();
    logic [23:0] v;
    // ch0 line, ch1 rx, ch2 tx, ch3 modem, ch4 line, ch5 rx, ch6 tx, ch7 modem
    apply(32'h8421_8421, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0);
    read_codes(v);
    chk("R2 packed layout", v, 24'h8D18D1);
    check_all();
    apply(32'h0, 8'hFF, 8'hFF, 8'hFF, 1'b0, 1'b0);
    check_all();
  endtask

  task automatic t_priority();
    logic [2:0] c;
    apply(32'h0000_000F, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0);
    code_of(0, c); chk("R3 line first", c, 3'd1);
    apply(32'h0, 8'h01, 8'h00, 8'h01, 1'b0, 1'b0);
    code_of(0, c); chk("R5 mismatched read ignored", c, 3'd1);
    apply(32'h0, 8'h00, 8'h01, 8'h00, 1'b0, 1'b0);
    code_of(0, c); chk("R3 rx second", c, 3'd2);
    apply(32'h0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0);
    apply(32'h0, 8'h01, 8'h00, 8'h00, 1'b0, 1'b0);
    code_of(0, c); chk("R3 tx third", c, 3'd3);
    apply(32'h0, 8'h00, 8'h01, 8'h01, 1'b0, 1'b0);
    code_of(0, c); chk("R5 lsr/msr do not clear tx", c, 3'd3);
    apply(32'h0, 8'h01, 8'h00, 8'h00, 1'b0, 1'b0);
    code_of(0, c); chk("R3 modem fourth", c, 3'd4);
    apply(32'h0, 8'h00, 8'h00, 8'h01, 1'b0, 1'b0);
    code_of(0, c); chk("R3 timer last", c, 3'd7);
    apply(32'h0, 8'h01, 8'h01, 8'h01, 1'b0, 1'b0);
    code_of(0, c); chk("R5 channel reads leave timer", c, 3'd7);
    apply(32'h0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1);
    code_of(0, c); chk("R6 timer read clears", c, 3'd0);
    check_all();
  endtask

  task automatic t_timer();
    logic [2:0] c;
    apply(32'h0, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0);
    for (int ch = 1; ch < 8; ch++) begin
      code_of(ch, c); chk("R4 no timer on upper ch", c, 3'd0);
    end
    apply(32'h0000_0048, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0);  // ch0 modem, ch1 tx
    code_of(1, c); chk("R4 ch1 shows tx not 7", c, 3'd3);
    code_of(0, c); chk("R3 modem over timer", c, 3'd4);
    check_all();
    apply(32'h0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1);
    code_of(0, c); chk("R6 masked after read", c, 3'd4);
    check_all();
    apply(32'h0, 8'h02, 8'h00, 8'h01, 1'b0, 1'b0);
    check_all();
  endtask

  task automatic t_collide();
    logic [2:0] c;
    apply(32'h0020_0000, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0);  // ch5 rx
    apply(32'h0020_0000, 8'h20, 8'h00, 8'h00, 1'b1, 1'b1);
    code_of(5, c); chk("R10 rx set wins", c, 3'd2);
    code_of(0, c); chk("R10 timer set wins", c, 3'd7);
    check_all();
    apply(32'h0, 8'h20, 8'h00, 8'h00, 1'b0, 1'b1);
    check_all();
  endtask

  task automatic t_irq();
    apply(32'h0800_0000, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0);  // ch6 modem
    chk("R8 irq raised", irq_o, 1'b1);
    @(negedge clk_i);
    msr_rd_i = 8'h40;
    #2;
    chk("R8 irq held before edge", irq_o, 1'b1);
    @(posedge clk_i);
    #2;
    chk("R8 irq falls after edge", irq_o, 1'b0);
    mf[6] = '0;
    @(negedge clk_i);
    msr_rd_i = '0;
    check_all();
  endtask

  task automatic t_reset_mid();
    apply(32'h0000_0400, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0);  // ch2 tx + timer
    @(negedge clk_i);
    rst_ni = 1'b0;
    model_reset();
    #1;
    check_all();  // R9 asynchronous clear
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all();
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog act=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_layout();
    t_priority();
    t_timer();
    t_collide();
    t_irq();
    t_reset_mid();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

endmodule